// File: doc/BRIEF.md
# Burst Bus Access Sequencer

This block sits on the processor side of an external memory bus. It takes one internal request at a time. Each request carries a start word address, a direction, a length in words, a privilege level and an atomic flag. The block turns that request into one or more bus accesses. Each access opens with a single address-strobe clock. It is followed by up to four data cycles, and each data cycle is preceded by a programmed number of wait clocks.

The settings of the addressed memory region come in with the request: the wait-state count, whether the external ready input is honoured, and whether the burst-stop input is honoured. When ready is honoured, it extends a data cycle once the programmed wait clocks have run out. When burst-stop is honoured, it ends the current access early, and a fresh address cycle continues the request from the first word not yet moved.

Data enable and lock span the whole request, including the extra address clocks of a split request. A one-clock transfer pulse marks every word moved, and the word address is valid on the bus during that clock.

Top module: `burstBusSeq`

## Requirements
- R1: `addrStrobeN` is low for exactly one clock at the start of every bus access, and `busAddr` then holds the word address of the first word of that access.
- R2: A request is split into accesses of min(remaining words, 4). Each access after the first starts at the word address that follows the last word moved.
- R3: Each data cycle is preceded by `cfgWaits` clocks with `waitStateN` low. With ready always given and no burst-stop, a request spends accesses + len × (cfgWaits + 1) clocks with `reqReady` low.
- R4: When `cfgReadyEn` is 1, a data cycle completes (`wordStrobe` high) only in a clock where `memReadyN` is low. When `cfgReadyEn` is 0, `memReadyN` is ignored and every data cycle completes at once.
- R5: `burstLastN` is low in the final data cycle of each access, only once the wait clocks are over. It stays low while ready holds that cycle open, and it is high in the clock after the word moves. It is high during wait clocks.
- R6: When `cfgTermEn` is 1 and `burstStopN` is low in a data cycle that is not the last of its access, the access ends and a new address cycle follows. If `memReadyN` is also low in that cycle, the word counts as moved; otherwise it is moved again in the new access. With `cfgTermEn` at 0, or in the last data cycle of an access, `burstStopN` has no effect.
- R7: `xmitDir` is 0 for reads and 1 for writes. It changes only while `dataEnN` is high.
- R8: `dataEnN` is high in the first address clock of a request. It is low from the first data cycle through the last data cycle of the request, including later address clocks, and it is high while idle.
- R9: For an atomic request, `busLockN` is low from the first address clock through the final data cycle. It rises in the same clock that `burstLastN` rises. For other requests it stays high.
- R10: `privUser` carries `reqUser` (0 supervisor, 1 user) during every clock of the request's accesses.
- R11: Under reset, `addrStrobeN`, `burstLastN`, `waitStateN`, `dataEnN`, `busLockN` and `privUser` are 1. `xmitDir` and `wordStrobe` are 0, and `reqReady` is 1.
- R12: A request with `reqLen` equal to 0 is taken but ignored: no address strobe follows and `reqReady` stays high.
- R13: Words move in ascending address order, one `wordStrobe` per word. `busAddr` holds that word's address in the clock of the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Sequencer idle; a request is taken when `reqValid` is high |
| reqAddr | input | ADDR_W | Start word address |
| reqLen | input | LEN_W | Number of words |
| reqWrite | input | 1 | 1 write, 0 read |
| reqUser | input | 1 | 1 user mode, 0 supervisor mode |
| reqAtomic | input | 1 | Atomic read-modify-write sequence |
| cfgWaits | input | WAIT_W | Wait clocks before each data cycle for the addressed region |
| cfgReadyEn | input | 1 | Region honours `memReadyN` |
| cfgTermEn | input | 1 | Region honours `burstStopN` |
| memReadyN | input | 1 | External ready, active low |
| burstStopN | input | 1 | External burst stop, active low |
| busAddr | output | ADDR_W | Current word address |
| addrStrobeN | output | 1 | Address strobe, active low |
| burstLastN | output | 1 | Last data cycle of access, active low |
| waitStateN | output | 1 | Programmed wait clock, active low |
| xmitDir | output | 1 | Transceiver direction, 1 transmit |
| dataEnN | output | 1 | Data enable, active low |
| busLockN | output | 1 | Bus lock, active low |
| privUser | output | 1 | Privilege of access, 1 user |
| wordStrobe | output | 1 | One word moved this clock |

## Verification
Single accesses, four-word bursts and split requests with zero, one and two wait clocks check the address sequence and the clock count against the formula. Stretching every word by one ready-high clock separates ready sampling from wait counting and shows that burst-last is held. Burst-stop is tried with and without ready in the same clock, on a final word, and with the region's enable off. These cases tell a re-addressed restart from a dropped or doubled word. A zero-length request and a region that ignores ready show that those inputs have no effect.

// File: rtl/burstBusPkg.sv
`timescale 1ns/1ps
package burstBusPkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic take;      // latch a new request
    logic startAcc;  // size a new access, load wait counter
    logic tick;      // count down one wait clock
    logic word;      // one word moved
  } seqStrb_t;

endpackage

// File: rtl/burstBusDpath.sv
`timescale 1ns/1ps
module burstBusDpath
  import burstBusPkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int LEN_W     = 6,
  parameter int WAIT_W    = 3,
  parameter int MAX_BURST = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrb_t          strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              reqWrite,
  input  logic              reqUser,
  input  logic              reqAtomic,
  input  logic [WAIT_W-1:0] cfgWaits,
  input  logic              cfgReadyEn,
  input  logic              cfgTermEn,
  output logic [ADDR_W-1:0] curAddr,
  output logic              waitZero,
  output logic              accLast,
  output logic              reqLast,
  output logic              rdyEn,
  output logic              termEn,
  output logic              isWrite,
  output logic              isUser,
  output logic              isAtomic
);

  localparam int ACC_W = $clog2(MAX_BURST + 1);
  localparam logic [LEN_W-1:0] BURST_LEN = LEN_W'(MAX_BURST);
  localparam logic [ACC_W-1:0] BURST_ACC = ACC_W'(MAX_BURST);

  logic [LEN_W-1:0]  remLeft;
  logic [ACC_W-1:0]  accLeft;
  logic [ACC_W-1:0]  accInit;
  logic [WAIT_W-1:0] waitCnt;
  logic [WAIT_W-1:0] waitCfg;

  assign accInit  = (remLeft > BURST_LEN) ? BURST_ACC : ACC_W'(remLeft);
  assign waitZero = (waitCnt == '0);
  assign accLast  = (accLeft == ACC_W'(1));
  assign reqLast  = (remLeft == LEN_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr  <= '0;
      remLeft  <= '0;
      accLeft  <= '0;
      waitCnt  <= '0;
      waitCfg  <= '0;
      rdyEn    <= 1'b0;
      termEn   <= 1'b0;
      isWrite  <= 1'b0;
      isUser   <= 1'b1;
      isAtomic <= 1'b0;
    end else begin
      if (strb.take) begin
        curAddr  <= reqAddr;
        remLeft  <= reqLen;
        waitCfg  <= cfgWaits;
        rdyEn    <= cfgReadyEn;
        termEn   <= cfgTermEn;
        isWrite  <= reqWrite;
        isUser   <= reqUser;
        isAtomic <= reqAtomic;
      end
      if (strb.startAcc) begin
        accLeft <= accInit;
        waitCnt <= waitCfg;
      end
      if (strb.tick) begin
        waitCnt <= waitCnt - WAIT_W'(1);
      end
      if (strb.word) begin
        curAddr <= curAddr + ADDR_W'(1);
        remLeft <= remLeft - LEN_W'(1);
        accLeft <= accLeft - ACC_W'(1);
        waitCnt <= waitCfg;
      end
    end
  end

  // R13
  word_in_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.word |-> (remLeft != '0 && accLeft != '0));

  // R3
  wait_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.tick |-> (waitCnt != '0));

  // R2
  acc_size_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.startAcc |=> (accLeft != '0 && accLeft <= BURST_ACC));

endmodule

// File: rtl/burstBusCtrl.sv
`timescale 1ns/1ps
module burstBusCtrl
  import burstBusPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     reqLenNz,
  input  logic     waitZero,
  input  logic     accLast,
  input  logic     reqLast,
  input  logic     rdyEn,
  input  logic     termEn,
  input  logic     isAtomic,
  input  logic     memReadyN,
  input  logic     burstStopN,
  output seqStrb_t strb,
  output logic     reqReady,
  output logic     addrStrobeN,
  output logic     waitStateN,
  output logic     burstLastN,
  output logic     dataEnN,
  output logic     busLockN,
  output logic     wordStrobe
);

  seqState_t state;
  seqState_t nextState;
  logic      denHeld;
  logic      rdyOk;
  logic      termOk;

  always_comb begin
    strb      = '0;
    nextState = state;
    rdyOk     = !rdyEn || !memReadyN;
    termOk    = termEn && !burstStopN && !accLast;
    unique case (state)
      ST_IDLE: begin
        if (reqValid && reqLenNz) begin
          strb.take = 1'b1;
          nextState = ST_ADDR;
        end
      end
      ST_ADDR: begin
        strb.startAcc = 1'b1;
        nextState     = ST_DATA;
      end
      ST_DATA: begin
        if (!waitZero) begin
          strb.tick = 1'b1;
        end else begin
          strb.word = rdyOk;
          if (rdyOk && reqLast) begin
            nextState = ST_IDLE;
          end else if (rdyOk && accLast) begin
            nextState = ST_ADDR;
          end else if (termOk) begin
            nextState = ST_ADDR;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      denHeld <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE) begin
        denHeld <= 1'b0;
      end else if (state == ST_DATA) begin
        denHeld <= 1'b1;
      end
    end
  end

  assign reqReady    = (state == ST_IDLE);
  assign addrStrobeN = (state != ST_ADDR);
  assign waitStateN  = !(state == ST_DATA && !waitZero);
  assign burstLastN  = !(state == ST_DATA && waitZero && accLast);
  assign dataEnN     = !(state == ST_DATA || (state == ST_ADDR && denHeld));
  assign busLockN    = !(state != ST_IDLE && isAtomic);
  assign wordStrobe  = strb.word;

  // R1
  strobe_one_clk_chk: assert property (@(posedge clk) disable iff (!rstN)
    !addrStrobeN |=> addrStrobeN);

  // R4
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wordStrobe && rdyEn) |-> !memReadyN);

  // R5
  last_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!burstLastN && !wordStrobe) |=> !burstLastN);

  // R5
  last_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!burstLastN && wordStrobe) |=> burstLastN);

  // R9
  lock_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busLockN) |-> $rose(burstLastN));

  // R8
  den_span_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!addrStrobeN && !dataEnN) |-> $past(!dataEnN));

  // R12
  zero_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && !(reqValid && reqLenNz)) |=> reqReady);

endmodule

// File: rtl/burstBusSeq.sv
`timescale 1ns/1ps
module burstBusSeq
  import burstBusPkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int LEN_W     = 6,
  parameter int WAIT_W    = 3,
  parameter int MAX_BURST = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              reqWrite,
  input  logic              reqUser,
  input  logic              reqAtomic,
  input  logic [WAIT_W-1:0] cfgWaits,
  input  logic              cfgReadyEn,
  input  logic              cfgTermEn,
  input  logic              memReadyN,
  input  logic              burstStopN,
  output logic [ADDR_W-1:0] busAddr,
  output logic              addrStrobeN,
  output logic              burstLastN,
  output logic              waitStateN,
  output logic              xmitDir,
  output logic              dataEnN,
  output logic              busLockN,
  output logic              privUser,
  output logic              wordStrobe
);

  seqStrb_t strb;
  logic     waitZero;
  logic     accLast;
  logic     reqLast;
  logic     rdyEn;
  logic     termEn;
  logic     isAtomic;
  logic     reqLenNz;

  assign reqLenNz = (reqLen != '0);

  burstBusCtrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqLenNz   (reqLenNz),
    .waitZero   (waitZero),
    .accLast    (accLast),
    .reqLast    (reqLast),
    .rdyEn      (rdyEn),
    .termEn     (termEn),
    .isAtomic   (isAtomic),
    .memReadyN  (memReadyN),
    .burstStopN (burstStopN),
    .strb       (strb),
    .reqReady   (reqReady),
    .addrStrobeN(addrStrobeN),
    .waitStateN (waitStateN),
    .burstLastN (burstLastN),
    .dataEnN    (dataEnN),
    .busLockN   (busLockN),
    .wordStrobe (wordStrobe)
  );

  burstBusDpath #(
    .ADDR_W   (ADDR_W),
    .LEN_W    (LEN_W),
    .WAIT_W   (WAIT_W),
    .MAX_BURST(MAX_BURST)
  ) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqAddr   (reqAddr),
    .reqLen    (reqLen),
    .reqWrite  (reqWrite),
    .reqUser   (reqUser),
    .reqAtomic (reqAtomic),
    .cfgWaits  (cfgWaits),
    .cfgReadyEn(cfgReadyEn),
    .cfgTermEn (cfgTermEn),
    .curAddr   (busAddr),
    .waitZero  (waitZero),
    .accLast   (accLast),
    .reqLast   (reqLast),
    .rdyEn     (rdyEn),
    .termEn    (termEn),
    .isWrite   (xmitDir),
    .isUser    (privUser),
    .isAtomic  (isAtomic)
  );

  // R7
  dir_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!dataEnN && $past(!dataEnN)) |-> $stable(xmitDir));

endmodule

// File: tb/burstBusSeq_tb_top.sv
`timescale 1ns/1ps
module burstBusSeq_tb_top;

  localparam int ADDR_W = 16;
  localparam int LEN_W  = 6;
  localparam int WAIT_W = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [LEN_W-1:0]  reqLen = '0;
  logic              reqWrite = 1'b0;
  logic              reqUser = 1'b0;
  logic              reqAtomic = 1'b0;
  logic [WAIT_W-1:0] cfgWaits = '0;
  logic              cfgReadyEn = 1'b1;
  logic              cfgTermEn = 1'b0;
  logic              memReadyN = 1'b1;
  logic              burstStopN = 1'b1;
  logic [ADDR_W-1:0] busAddr;
  logic              addrStrobeN, burstLastN, waitStateN, xmitDir;
  logic              dataEnN, busLockN, privUser, wordStrobe;

  burstBusSeq dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqWrite(reqWrite), .reqUser(reqUser),
    .reqAtomic(reqAtomic), .cfgWaits(cfgWaits), .cfgReadyEn(cfgReadyEn),
    .cfgTermEn(cfgTermEn), .memReadyN(memReadyN), .burstStopN(burstStopN),
    .busAddr(busAddr), .addrStrobeN(addrStrobeN), .burstLastN(burstLastN),
    .waitStateN(waitStateN), .xmitDir(xmitDir), .dataEnN(dataEnN),
    .busLockN(busLockN), .privUser(privUser), .wordStrobe(wordStrobe)
  );

  int passCnt = 0;
  int failCnt = 0;
  bit doneFlag = 0;

  // scoreboard queues, filled by the driver, drained by the monitor
  int adsAddrQ[$];
  int adsLenQ[$];
  int wordQ[$];

  // driver-owned request context
  bit expWrite = 0, expUser = 0, expAtomic = 0;
  int expWaits = 0;
  bit stallMode = 0, holdHigh = 0, termReady = 1;
  int termAt = -1;
  int reqSeq = 0;

  // monitor-owned state
  int seenSeq = 0;
  bit started = 0, termUsed = 0, stallPrev = 0;
  int wordCnt = 0, run = 0, accLeftExp = 0;
  bit dataCyc, expWord;
  int popA, popL;

  task automatic chkEq(string req, string what, int act, int exp);
    if (act == exp) passCnt++;
    else begin
      failCnt++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: drive bus responses, then compare outputs
  always @(negedge clk) begin
    if (rstN && !doneFlag) begin
      dataCyc = !dataEnN && addrStrobeN && waitStateN;
      memReadyN  = 1'b1;
      burstStopN = 1'b1;
      if (dataCyc) begin
        memReadyN = (holdHigh || (stallMode && !stallPrev)) ? 1'b1 : 1'b0;
        if (!termUsed && termAt >= 0 && wordCnt == termAt) begin
          burstStopN = 1'b0;
          memReadyN  = !termReady;
          termUsed   = 1;
        end
      end
      #1;
      if (reqSeq != seenSeq) begin
        seenSeq = reqSeq; started = 0; wordCnt = 0; termUsed = 0;
        run = 0; stallPrev = 0;
      end
      if (!addrStrobeN) begin
        if (adsAddrQ.size() == 0) chkEq("R1", "unexpected address strobe", 1, 0);
        else begin
          popA = adsAddrQ.pop_front();
          popL = adsLenQ.pop_front();
          chkEq("R2", "access start address", int'(busAddr), popA);
          accLeftExp = popL;
        end
        chkEq("R7", "direction at strobe", int'(xmitDir), int'(expWrite));
        chkEq("R10", "privilege at strobe", int'(privUser), int'(expUser));
        chkEq("R8", "data enable at strobe", int'(dataEnN), started ? 0 : 1);
        started = 1;
        run = 0;
      end
      if (!waitStateN) begin
        run++;
        chkEq("R5", "burst-last during wait", int'(burstLastN), 1);
        chkEq("R8", "data enable during wait", int'(dataEnN), 0);
      end
      if (dataCyc) begin
        if (!stallPrev) chkEq("R3", "wait clocks before data cycle", run, expWaits);
        run = 0;
        chkEq("R5", "burst-last in data cycle", int'(burstLastN), (accLeftExp == 1) ? 0 : 1);
        chkEq("R10", "privilege in data cycle", int'(privUser), int'(expUser));
        expWord = holdHigh ? 1'b1 : !memReadyN;
        chkEq("R4", "word completion", int'(wordStrobe), int'(expWord));
        if (wordStrobe) begin
          if (wordQ.size() == 0) chkEq("R13", "unexpected word", 1, 0);
          else chkEq("R13", "word address", int'(busAddr), wordQ.pop_front());
          accLeftExp--;
          wordCnt++;
        end
      end else begin
        chkEq("R13", "no word outside data cycle", int'(wordStrobe), 0);
      end
      chkEq("R9", "lock level", int'(busLockN), (expAtomic && !reqReady) ? 0 : 1);
      if (reqReady) chkEq("R8", "data enable when idle", int'(dataEnN), 1);
      stallPrev = dataCyc && !wordStrobe;
    end
  end

  // driver: model the expected accesses and words, then issue the request
  task automatic runReq(string name, int addr, int len, bit wr, bit usr, bit atom,
                        int waits, bit rdyEn, bit tEn, int tAt, bit tRdy,
                        bit stall, bit hold, int expLat);
    int pos, n, tA, lat;
    bit brk;
    pos = 0;
    tA = tAt;
    while (pos < len) begin
      n = (len - pos > 4) ? 4 : len - pos;
      adsAddrQ.push_back(addr + pos);
      adsLenQ.push_back(n);
      brk = 0;
      for (int i = 0; i < n; i++) begin
        if (!brk && tEn && tA == pos + i && i != n - 1) begin
          brk = 1;
          pos = tRdy ? pos + i + 1 : pos + i;
          tA = -1;
        end
      end
      if (!brk) pos += n;
    end
    for (int i = 0; i < len; i++) wordQ.push_back(addr + i);
    expWrite = wr; expUser = usr; expAtomic = atom; expWaits = waits;
    stallMode = stall; holdHigh = hold; termAt = tAt; termReady = tRdy;
    reqSeq++;
    reqValid   = 1'b1;
    reqAddr    = ADDR_W'(addr);
    reqLen     = LEN_W'(len);
    reqWrite   = wr;
    reqUser    = usr;
    reqAtomic  = atom;
    cfgWaits   = WAIT_W'(waits);
    cfgReadyEn = rdyEn;
    cfgTermEn  = tEn;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 0;
    while (!reqReady) begin
      lat++;
      @(negedge clk);
    end
    if (expLat >= 0) chkEq("R3", {"busy clocks of ", name}, lat, expLat);
    repeat (3) @(negedge clk);
    chkEq("R2", {"access strobes left after ", name}, adsAddrQ.size(), 0);
    chkEq("R13", {"words left after ", name}, wordQ.size(), 0);
    adsAddrQ.delete();
    adsLenQ.delete();
    wordQ.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chkEq("R11", "strobe in reset", int'(addrStrobeN), 1);
    chkEq("R11", "burst-last in reset", int'(burstLastN), 1);
    chkEq("R11", "wait in reset", int'(waitStateN), 1);
    chkEq("R11", "data enable in reset", int'(dataEnN), 1);
    chkEq("R11", "lock in reset", int'(busLockN), 1);
    chkEq("R11", "privilege in reset", int'(privUser), 1);
    chkEq("R11", "direction in reset", int'(xmitDir), 0);
    chkEq("R11", "word pulse in reset", int'(wordStrobe), 0);
    chkEq("R11", "ready in reset", int'(reqReady), 1);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chkEq("R11", "ready after reset", int'(reqReady), 1);

    //      name           addr   len wr us at W rdy tEn tAt tRdy stall hold lat
    runReq("single3",      'h10,   3, 0, 0, 0, 0, 1, 0, -1, 1, 0, 0, 4);   // R1 R3
    runReq("split9",       'h40,   9, 1, 1, 1, 2, 1, 0, -1, 1, 0, 0, 30);  // R2 R9 R7
    runReq("stall5",       'h80,   5, 0, 1, 0, 1, 1, 0, -1, 1, 1, 0, -1);  // R4 R5
    runReq("noReady2",     'h100,  2, 1, 0, 0, 1, 0, 0, -1, 1, 0, 1, 5);   // R4 ignored
    runReq("termRdy6",     'h200,  6, 0, 0, 1, 0, 1, 1,  1, 1, 0, 0, -1);  // R6 counted
    runReq("termNoRdy4",   'h300,  4, 1, 1, 0, 1, 1, 1,  2, 0, 0, 0, -1);  // R6 replayed
    runReq("termOff4",     'h400,  4, 0, 0, 0, 0, 1, 0,  1, 1, 0, 0, 5);   // R6 ignored
    runReq("termLast8",    'h500,  8, 1, 0, 0, 0, 1, 1,  3, 1, 0, 0, 10);  // R6 final word
    runReq("zeroLen",      'h600,  0, 1, 1, 1, 0, 1, 0, -1, 1, 0, 0, 0);   // R12
    runReq("atomic6",      'h700,  6, 1, 0, 1, 2, 1, 0, -1, 1, 0, 0, 20);  // R9 R3
    runReq("termFirst4",   'h800,  4, 0, 1, 1, 0, 1, 1,  0, 1, 0, 0, -1);  // R6 R8

    doneFlag = 1;
    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!doneFlag) begin
      doneFlag = 1;
      failCnt++;
      $display("FAIL R13 watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
      $finish;
    end
  end

endmodule